// File: doc/BRIEF.md
# DSI Read Response Parser

This block runs on the host side of a display serial link, after the host has sent a read command to a panel. It pops 32-bit words from a show-ahead receive FIFO and decodes the response that comes back. Short responses carry one or two bytes inside the first word. Long responses give a payload length in the first word, and the payload follows in later words. The parser puts the bytes it recovers onto a byte stream, one byte per cycle. It never delivers more bytes than were requested, and it rejects a long response that claims more bytes than that.

When the transfer is over, whether it completed, was rejected or timed out, the parser keeps popping leftover words. It stops at the empty marker word 0x30800002, when the FIFO runs empty, or after 64 pops. This leaves the FIFO clean for the next read. A one-cycle `done` pulse then reports the byte count and the two error flags. Packet ECC and CRC checking are handled elsewhere.

Top module: `dsi_rsp_parser`

## Requirements
- R1: During reset and right after it, `fifo_pop`, `byte_valid`, `done`, `len_err` and `tmo_err` are 0 and `rx_count` is 0.
- R2: A first word whose bits 5:0 hold 0x11 or 0x21 is a one-byte short response. Exactly one byte, taken from bits 15:8, is delivered, and `rx_count` ends at 1.
- R3: A first word whose bits 5:0 hold 0x12 or 0x22 is a two-byte short response. The byte from bits 15:8 comes first. The byte from bits 23:16 follows only if the requested length is at least 2. `rx_count` ends at the number of bytes delivered.
- R4: For any other type, bits 23:8 give the payload length. If that length is greater than the requested length, `len_err` is set, no byte is delivered and `rx_count` ends at 0.
- R5: A long response whose length L is at most the requested length delivers exactly L bytes, and `rx_count` ends at L. L = 0 completes with no bytes. `rx_count` rises by one for every byte delivered.
- R6: Payload words are unpacked little-endian: bits 7:0 first, then 15:8, 23:16 and 31:24. From the last word, only as many low-order bytes as are still needed are delivered.
- R7: After the transfer ends (completed, rejected or timed out), words are popped until one of three things happens: a popped word equals 0x30800002 (that word is consumed), the FIFO is empty, or 64 words have been popped in this phase. Words behind the marker stay in the FIFO.
- R8: If the FIFO stays empty for TMO_CYC consecutive cycles while a header or payload word is awaited, `tmo_err` is set, the FIFO is drained and the transfer ends with the bytes delivered so far.
- R9: Each accepted `start` gives exactly one single-cycle `done` pulse. `start` and `req_len` are ignored while a transfer is in progress.
- R10: `fifo_pop` is never asserted while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin parsing a response (accepted when idle) |
| req_len | input | LEN_W | Number of bytes requested by the read command |
| fifo_empty | input | 1 | Receive FIFO has no word |
| fifo_data | input | 32 | Head word of the show-ahead receive FIFO |
| fifo_pop | output | 1 | Consume the head word this cycle |
| byte_valid | output | 1 | `byte_data` carries a received byte |
| byte_data | output | 8 | Received byte |
| rx_count | output | LEN_W | Bytes delivered in the current or last transfer |
| done | output | 1 | One-cycle pulse when the transfer has ended |
| len_err | output | 1 | Last transfer was rejected as over-length |
| tmo_err | output | 1 | Last transfer timed out waiting for the FIFO |

## Verification
The assertions assume a FIFO that presents a valid head word whenever `fifo_empty` is low and removes it only on `fifo_pop`. They also assume the requested length is at least 1 whenever a short response is possible. The stimulus keeps to these assumptions: a queue in the bench acts as the FIFO and updates its head only between edges, and every short-response case requests one or more bytes. Busy-time `start` pulses, stalled payloads, over-length headers and long leftover tails are all produced through that same queue, so the assumptions hold even in the corner cases.

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser #(
  parameter int          LEN_W     = 16,
  parameter int          TMO_CYC   = 1024,
  parameter int          DRAIN_MAX = 64,
  parameter logic [31:0] MARKER    = 32'h3080_0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] req_len,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_data,
  output logic             fifo_pop,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [LEN_W-1:0] rx_count,
  output logic             done,
  output logic             len_err,
  output logic             tmo_err
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam int DW    = $clog2(DRAIN_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_EMIT, S_DRAIN, S_FIN} st_t;

  st_t              st;
  logic [LEN_W-1:0] req_q, exp_q, cnt_q;
  logic [31:0]      sh;
  logic [2:0]       nb;
  logic [TMO_W-1:0] tmo_q;
  logic [DW-1:0]    dcnt;
  logic             len_err_q, tmo_err_q;

  wire [5:0]       typ      = fifo_data[5:0];
  wire [15:0]      hdr_len  = fifo_data[23:8];
  wire             short1   = (typ == 6'h11) || (typ == 6'h21);
  wire             short2   = (typ == 6'h12) || (typ == 6'h22);
  wire             waiting  = (st == S_HDR) || (st == S_PAY);
  wire [LEN_W-1:0] remain   = exp_q - cnt_q;
  wire [2:0]       nb_load  = (remain > LEN_W'(3)) ? 3'd4 : remain[2:0];
  wire             tmo_hit  = tmo_q == TMO_W'(TMO_CYC - 1);
  wire             too_long = 32'(hdr_len) > 32'(req_q);

  assign fifo_pop   = !fifo_empty && (waiting || st == S_DRAIN);
  assign byte_valid = st == S_EMIT;
  assign byte_data  = sh[7:0];
  assign done       = st == S_FIN;
  assign rx_count   = cnt_q;
  assign len_err    = len_err_q;
  assign tmo_err    = tmo_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      req_q     <= '0;
      exp_q     <= '0;
      cnt_q     <= '0;
      sh        <= '0;
      nb        <= '0;
      tmo_q     <= '0;
      dcnt      <= '0;
      len_err_q <= 1'b0;
      tmo_err_q <= 1'b0;
    end else begin
      if (waiting) begin
        if (fifo_empty) begin
          if (tmo_hit) begin
            tmo_err_q <= 1'b1;
            st        <= S_DRAIN;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end else begin
          tmo_q <= '0;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          req_q     <= req_len;
          cnt_q     <= '0;
          len_err_q <= 1'b0;
          tmo_err_q <= 1'b0;
          tmo_q     <= '0;
          dcnt      <= '0;
          st        <= S_HDR;
        end
        S_HDR: if (!fifo_empty) begin
          if (short1 || short2) begin
            sh <= fifo_data >> 8;
            if (short2 && req_q >= LEN_W'(2)) begin
              nb    <= 3'd2;
              exp_q <= LEN_W'(2);
            end else begin
              nb    <= 3'd1;
              exp_q <= LEN_W'(1);
            end
            st <= S_EMIT;
          end else if (too_long) begin
            len_err_q <= 1'b1;
            st        <= S_DRAIN;
          end else if (hdr_len == 16'd0) begin
            st <= S_DRAIN;
          end else begin
            exp_q <= LEN_W'(hdr_len);
            st    <= S_PAY;
          end
        end
        S_PAY: if (!fifo_empty) begin
          sh <= fifo_data;
          nb <= nb_load;
          st <= S_EMIT;
        end
        S_EMIT: begin
          sh    <= sh >> 8;
          cnt_q <= cnt_q + LEN_W'(1);
          nb    <= nb - 3'd1;
          if (nb == 3'd1)
            st <= ((cnt_q + LEN_W'(1)) == exp_q) ? S_DRAIN : S_PAY;
        end
        S_DRAIN: begin
          if (fifo_empty || fifo_data == MARKER || dcnt == DW'(DRAIN_MAX - 1))
            st <= S_FIN;
          else
            dcnt <= dcnt + DW'(1);
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dsi_rsp_parser_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             byte_valid,
  input logic [LEN_W-1:0] rx_count,
  input logic             done,
  input logic             len_err,
  input logic             tmo_err
);
  a_r10_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_err_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_err) |-> rx_count == '0);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> rx_count == $past(rx_count) + LEN_W'(1));

  a_r8_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(len_err && tmo_err));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!done && !byte_valid && rx_count == '0));
endmodule

bind dsi_rsp_parser dsi_rsp_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .byte_valid(byte_valid), .rx_count(rx_count), .done(done),
  .len_err(len_err), .tmo_err(tmo_err)
);

// File: tb/dsi_rsp_parser_test.sv
module dsi_rsp_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam int LW = 16;
  localparam logic [31:0] MARK = 32'h3080_0002;
  localparam int M_IDLE = 0, M_HDR = 1, M_PAY = 2, M_EMIT = 3, M_DRAIN = 4, M_FIN = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic fifo_empty = 1'b1;
  logic [31:0] fifo_data = '0;
  logic fifo_pop, byte_valid, done, len_err, tmo_err;
  logic [7:0] byte_data;
  logic [LW-1:0] rx_count;

  dsi_rsp_parser #(.LEN_W(LW), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .byte_valid(byte_valid), .byte_data(byte_data), .rx_count(rx_count),
    .done(done), .len_err(len_err), .tmo_err(tmo_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] fq[$];
  logic [31:0] early[$], late[$];
  logic [7:0] got[$], xb[$];
  logic [7:0] pend[$];
  bit done_seen, r_le, r_te;
  int done_n, r_cnt;
  int m_st = M_IDLE, m_req, m_exp, m_cnt, m_tmo, m_dcnt;
  bit m_le, m_te;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [31:0] d;
    int t, len;
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() > 0) ? fq[0] : 32'h0;
    #1;
    d = fifo_data;
    if (!rst_n) begin
      m_st = M_IDLE; m_cnt = 0; m_le = 0; m_te = 0; pend.delete();
      chk(!fifo_pop && !byte_valid && !done && !len_err && !tmo_err && rx_count == 0,
          "R1", "outputs in reset", int'(rx_count), 0);
    end else begin
      chk(fifo_pop == (!fifo_empty && (m_st == M_HDR || m_st == M_PAY || m_st == M_DRAIN)),
          "R7/R10", "fifo_pop", fifo_pop, int'(!fifo_empty && (m_st == M_HDR || m_st == M_PAY || m_st == M_DRAIN)));
      chk(byte_valid == (m_st == M_EMIT), "R5", "byte_valid", byte_valid, int'(m_st == M_EMIT));
      if (m_st == M_EMIT && byte_valid)
        chk(byte_data == pend[0], "R6", "byte_data", byte_data, pend[0]);
      chk(int'(rx_count) == m_cnt, "R5", "rx_count", rx_count, m_cnt);
      chk(done == (m_st == M_FIN), "R9", "done", done, int'(m_st == M_FIN));
      chk(len_err == m_le, "R4", "len_err", len_err, m_le);
      chk(tmo_err == m_te, "R8", "tmo_err", tmo_err, m_te);
      if (byte_valid) got.push_back(byte_data);
      if (done) begin
        done_seen = 1; done_n++; r_cnt = rx_count; r_le = len_err; r_te = tmo_err;
      end
      case (m_st)
        M_IDLE: if (start) begin
          m_req = req_len; m_cnt = 0; m_le = 0; m_te = 0; m_tmo = 0; m_dcnt = 0; m_st = M_HDR;
        end
        M_HDR, M_PAY: begin
          if (fifo_empty) begin
            if (m_tmo == TMO - 1) begin m_te = 1; m_st = M_DRAIN; end
            else m_tmo++;
          end else begin
            m_tmo = 0;
            if (m_st == M_PAY) begin
              for (int k = 0; k < 4 && m_cnt + k < m_exp; k++) pend.push_back(d[8*k +: 8]);
              m_st = M_EMIT;
            end else begin
              t = d[5:0]; len = d[23:8];
              if (t == 'h11 || t == 'h21) begin
                pend.push_back(d[15:8]); m_exp = 1; m_st = M_EMIT;
              end else if (t == 'h12 || t == 'h22) begin
                pend.push_back(d[15:8]);
                if (m_req >= 2) pend.push_back(d[23:16]);
                m_exp = pend.size(); m_st = M_EMIT;
              end else if (len > m_req) begin
                m_le = 1; m_st = M_DRAIN;
              end else if (len == 0) m_st = M_DRAIN;
              else begin m_exp = len; m_st = M_PAY; end
            end
          end
        end
        M_EMIT: begin
          void'(pend.pop_front()); m_cnt++;
          if (pend.size() == 0) m_st = (m_cnt == m_exp) ? M_DRAIN : M_PAY;
        end
        M_DRAIN: begin
          if (fifo_empty || d == MARK || m_dcnt == 63) m_st = M_FIN;
          else m_dcnt++;
        end
        default: m_st = M_IDLE;
      endcase
    end
  end

  task automatic run(input string tag, input int req, input int delay, input bit busy_pulse,
                     input int xcnt, input bit xle, input bit xte, input int xleft);
    int n;
    @(posedge clk); #1;
    fq.delete();
    foreach (early[i]) fq.push_back(early[i]);
    got.delete(); done_seen = 0; done_n = 0;
    req_len = LW'(req); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < delay; i++) begin
      @(posedge clk); #1;
      if (busy_pulse && i == 1) begin start = 1'b1; req_len = LW'(2); end
      else start = 1'b0;
    end
    start = 1'b0;
    foreach (late[i]) fq.push_back(late[i]);
    n = 0;
    while (!done_seen && n < 2000) begin @(posedge clk); n++; end
    repeat (3) @(posedge clk);
    #1;
    chk(done_n == 1, "R9", {tag, " done pulses"}, done_n, 1);
    chk(got.size() == xb.size(), tag, "byte total", got.size(), xb.size());
    foreach (xb[i]) if (i < got.size()) chk(got[i] == xb[i], tag, "byte value", got[i], xb[i]);
    chk(r_cnt == xcnt, tag, "final rx_count", r_cnt, xcnt);
    chk(r_le == xle, "R4", {tag, " len_err"}, r_le, xle);
    chk(r_te == xte, "R8", {tag, " tmo_err"}, r_te, xte);
    chk(fq.size() == xleft, "R7", {tag, " words left"}, fq.size(), xleft);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    early = '{32'h0000_5A21, MARK}; late = {}; xb = '{8'h5A};
    run("R2 one-byte", 4, 0, 0, 1, 0, 0, 0);

    early = '{32'h0000_7711, 32'h1234_5678, MARK, 32'h0000_0099}; xb = '{8'h77};
    run("R2/R7 one-byte marker stop", 1, 0, 0, 1, 0, 0, 1);

    early = '{32'h00C3_B412}; xb = '{8'hB4, 8'hC3};
    run("R3 two-byte", 2, 0, 0, 2, 0, 0, 0);

    early = '{32'h00C3_B422, MARK}; xb = '{8'hB4};
    run("R3 two-byte clipped", 1, 0, 0, 1, 0, 0, 0);

    early = '{32'h0000_061A, 32'h4433_2211, 32'hAAAA_6655, 32'hDEAD_BEEF, MARK, 32'h1234_5678};
    xb = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    run("R5/R6 long short-of-request", 8, 0, 0, 6, 0, 0, 1);

    early = '{32'h0000_0529, 32'h0403_0201, 32'hFFFF_FF05};
    xb = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    run("R6 partial last word", 5, 0, 0, 5, 0, 0, 0);

    early = '{32'h0000_0A1A, 32'h1111_1111, MARK, 32'h2222_2222}; xb = {};
    run("R4 over-length", 4, 0, 0, 0, 1, 0, 1);

    early = '{32'h0000_041A}; late = '{32'h0D0C_0B0A};
    xb = '{8'h0A, 8'h0B, 8'h0C, 8'h0D};
    run("R9/R5 stalled payload with busy start", 4, 5, 1, 4, 0, 0, 0);
    late = {};

    early = '{32'h0000_001A, MARK}; xb = {};
    run("R5 zero length", 3, 0, 0, 0, 0, 0, 0);

    early = '{32'h0000_081A, 32'h0403_0201}; xb = '{8'h01, 8'h02, 8'h03, 8'h04};
    run("R8 payload timeout", 8, 0, 0, 4, 0, 1, 0);

    early = {}; xb = {};
    run("R8 header timeout", 4, 0, 0, 0, 0, 1, 0);

    early = '{32'h0000_3C21};
    for (int i = 0; i < 70; i++) early.push_back(32'h0000_0001 + i);
    xb = '{8'h3C};
    run("R7 drain limit", 2, 0, 0, 1, 0, 0, 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule